// File: doc/BRIEF.md
# Load-Adaptive Flit Migration Controller

This controller sits beside one virtual channel of a hybrid router input buffer. That buffer pairs a small, fast storage that writes in a single cycle with a larger, slow storage whose writes take several cycles. Every flit is written into the fast storage first. The controller then decides, in the same cycle the flit arrives, whether that flit should also start a migration into the slow storage. The buffer datapath that moves the flits is outside this block. The controller only sees event strobes and returns a per-arrival migrate-enable.

In lazy mode, load is estimated from a single quantity: the number of flits held in fast storage. Migration is requested only when that occupancy, counting the arriving flit, is strictly above a programmable fraction of the fast capacity. At light load, flits usually leave before a slow write could finish. Keeping them in fast storage saves the energy of slow writes. In eager mode, every arrival is migrated whenever a slow entry is free.

The block keeps a reservation count of slow entries and refuses to migrate when none is free. It also counts the migrations it starts and the migrations that get cancelled, so that the write activity of the two modes can be compared.

Top module: `lazy_mig_ctrl`

## Requirements
- R1: After reset, fastCount, slowCount, startCount and cancelCount are all zero.
- R2: fastCount rises by one for each arrival. It falls by one for each of fastDepart, migDone and migCancel in the same cycle. The new value is visible after the next rising clock edge.
- R3: In lazy mode (eagerMode=0), an arrival raises migrateEn in its own cycle when (fastCount+1)·2^THR_FRAC is greater than thrNum·FAST_DEPTH and a slow entry is free.
- R4: In lazy mode, an arrival whose (fastCount+1)·2^THR_FRAC equals or is below thrNum·FAST_DEPTH leaves migrateEn low. With the default parameters and thrNum=4, this means no migration for the first three held flits.
- R5: In eager mode (eagerMode=1), every arrival raises migrateEn in its own cycle when a slow entry is free, whatever the occupancy.
- R6: slowCount rises by one per started migration and falls by one for each of slowDepart and migCancel. migrateEn stays low while slowCount equals SLOW_DEPTH.
- R7: startCount increases by exactly one after each cycle in which migrateEn is high, and holds otherwise.
- R8: cancelCount increases by exactly one after each cycle in which migCancel is high, and holds otherwise.
- R9: migrateEn is low in every cycle without an arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arrive | input | 1 | A flit is written into fast storage this cycle |
| fastDepart | input | 1 | A non-migrating flit leaves fast storage |
| migDone | input | 1 | A slow write finished; its fast entry is released |
| migCancel | input | 1 | A migrating flit left before its slow write finished |
| slowDepart | input | 1 | A flit leaves slow storage |
| eagerMode | input | 1 | 1 = migrate every arrival, 0 = occupancy-gated |
| thrNum | input | THR_FRAC+1 | Threshold numerator over 2^THR_FRAC |
| migrateEn | output | 1 | Start migration of the flit arriving this cycle |
| fastCount | output | $clog2(FAST_DEPTH+1) | Flits held in fast storage |
| slowCount | output | $clog2(SLOW_DEPTH+1) | Slow entries used or reserved |
| startCount | output | CNT_W | Migrations started (wrapping) |
| cancelCount | output | CNT_W | Migrations cancelled (wrapping) |

## Verification
migrateEn is combinational, so the bench reads it one time step after driving an arrival, still inside the same cycle, before the rising edge. The four counts are registered and change at the first rising edge after their strobes. The bench therefore reads them at the following falling edge and compares them with a model that was updated at that same edge. The random stimulus only issues event combinations a real buffer could produce: no departure from an empty store, and no completion without a migration in flight.

// File: rtl/lazy_mig_pkg.sv
package lazy_mig_pkg;
  // Strobes from the decision logic to the counting datapath.
  typedef struct packed {
    logic arrive;
    logic fastDep;
    logic done;
    logic cancel;
    logic slowDep;
    logic start;
  } migStrobe_t;
endpackage

// File: rtl/lazy_mig_decide.sv
module lazy_mig_decide
  import lazy_mig_pkg::*;
#(
  parameter int FAST_DEPTH = 6,
  parameter int SLOW_DEPTH = 12,
  parameter int THR_FRAC = 3,
  localparam int THR_W = THR_FRAC + 1,
  localparam int FC_W = $clog2(FAST_DEPTH + 1),
  localparam int SC_W = $clog2(SLOW_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arrive,
  input  logic             fastDepart,
  input  logic             migDone,
  input  logic             migCancel,
  input  logic             slowDepart,
  input  logic             eagerMode,
  input  logic [THR_W-1:0] thrNum,
  input  logic [FC_W-1:0]  fastCount,
  input  logic [SC_W-1:0]  slowCount,
  output migStrobe_t       st
);
  logic [31:0] occScaled;
  logic [31:0] thrScaled;
  logic        overThr;
  logic        slowRoom;

  // Division-free ratio test: (occ+1)/FAST_DEPTH > thrNum/2^THR_FRAC
  always_comb begin
    occScaled = (32'(fastCount) + 32'd1) << THR_FRAC;
    thrScaled = 32'(thrNum) * 32'(FAST_DEPTH);
    overThr   = occScaled > thrScaled;
    slowRoom  = slowCount < SC_W'(SLOW_DEPTH);
  end

  always_comb begin
    st.arrive  = arrive;
    st.fastDep = fastDepart;
    st.done    = migDone;
    st.cancel  = migCancel;
    st.slowDep = slowDepart;
    st.start   = arrive && slowRoom && (eagerMode || overThr);
  end

  // R9
  no_idle_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !arrive |-> !st.start);
endmodule

// File: rtl/lazy_mig_count.sv
module lazy_mig_count
  import lazy_mig_pkg::*;
#(
  parameter int FAST_DEPTH = 6,
  parameter int SLOW_DEPTH = 12,
  parameter int CNT_W = 16,
  localparam int FC_W = $clog2(FAST_DEPTH + 1),
  localparam int SC_W = $clog2(SLOW_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  migStrobe_t       st,
  output logic [FC_W-1:0]  fastCount,
  output logic [SC_W-1:0]  slowCount,
  output logic [CNT_W-1:0] startCount,
  output logic [CNT_W-1:0] cancelCount
);
  logic [FC_W-1:0] fastNext;
  logic [SC_W-1:0] slowNext;

  always_comb begin
    fastNext = fastCount + FC_W'(st.arrive) - FC_W'(st.fastDep)
             - FC_W'(st.done) - FC_W'(st.cancel);
    slowNext = slowCount + SC_W'(st.start) - SC_W'(st.slowDep)
             - SC_W'(st.cancel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastCount   <= '0;
      slowCount   <= '0;
      startCount  <= '0;
      cancelCount <= '0;
    end else begin
      fastCount   <= fastNext;
      slowCount   <= slowNext;
      startCount  <= startCount + CNT_W'(st.start);
      cancelCount <= cancelCount + CNT_W'(st.cancel);
    end
  end

  // R2
  fast_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastCount <= FC_W'(FAST_DEPTH));
  // R6
  slow_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    slowCount <= SC_W'(SLOW_DEPTH));
  // R6
  slow_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slowCount == SC_W'(SLOW_DEPTH)) |-> !st.start);
  // R7
  start_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.start |=> startCount == $past(startCount) + CNT_W'(1));
  // R7
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.start |=> $stable(startCount));
  // R8
  cancel_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.cancel |=> cancelCount == $past(cancelCount) + CNT_W'(1));
endmodule

// File: rtl/lazy_mig_ctrl.sv
module lazy_mig_ctrl
  import lazy_mig_pkg::*;
#(
  parameter int FAST_DEPTH = 6,
  parameter int SLOW_DEPTH = 12,
  parameter int THR_FRAC = 3,
  parameter int CNT_W = 16,
  localparam int THR_W = THR_FRAC + 1,
  localparam int FC_W = $clog2(FAST_DEPTH + 1),
  localparam int SC_W = $clog2(SLOW_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arrive,
  input  logic             fastDepart,
  input  logic             migDone,
  input  logic             migCancel,
  input  logic             slowDepart,
  input  logic             eagerMode,
  input  logic [THR_W-1:0] thrNum,
  output logic             migrateEn,
  output logic [FC_W-1:0]  fastCount,
  output logic [SC_W-1:0]  slowCount,
  output logic [CNT_W-1:0] startCount,
  output logic [CNT_W-1:0] cancelCount
);
  migStrobe_t st;

  lazy_mig_decide #(
    .FAST_DEPTH(FAST_DEPTH), .SLOW_DEPTH(SLOW_DEPTH), .THR_FRAC(THR_FRAC)
  ) i_decide (
    .clk(clk), .rstN(rstN), .arrive(arrive), .fastDepart(fastDepart),
    .migDone(migDone), .migCancel(migCancel), .slowDepart(slowDepart),
    .eagerMode(eagerMode), .thrNum(thrNum), .fastCount(fastCount),
    .slowCount(slowCount), .st(st)
  );

  lazy_mig_count #(
    .FAST_DEPTH(FAST_DEPTH), .SLOW_DEPTH(SLOW_DEPTH), .CNT_W(CNT_W)
  ) i_count (
    .clk(clk), .rstN(rstN), .st(st), .fastCount(fastCount),
    .slowCount(slowCount), .startCount(startCount), .cancelCount(cancelCount)
  );

  assign migrateEn = st.start;
endmodule

// File: tb/test_lazy_mig_ctrl.sv
module test_lazy_mig_ctrl;
  localparam int FAST = 6;
  localparam int SLOW = 12;
  localparam int FRAC = 3;
  localparam int DEN = 1 << FRAC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arrive = 0, fastDepart = 0, migDone = 0, migCancel = 0, slowDepart = 0;
  logic eagerMode = 0;
  logic [FRAC:0] thrNum = 4'd4;
  logic migrateEn;
  logic [2:0] fastCount;
  logic [3:0] slowCount;
  logic [15:0] startCount, cancelCount;

  int checks = 0, errors = 0;
  int mFast = 0, mSlow = 0, mFlight = 0, mStarts = 0, mCancels = 0;

  always #10 clk = ~clk;

  lazy_mig_ctrl i_lazy_mig_ctrl (
    .clk(clk), .rstN(rstN), .arrive(arrive), .fastDepart(fastDepart),
    .migDone(migDone), .migCancel(migCancel), .slowDepart(slowDepart),
    .eagerMode(eagerMode), .thrNum(thrNum), .migrateEn(migrateEn),
    .fastCount(fastCount), .slowCount(slowCount), .startCount(startCount),
    .cancelCount(cancelCount)
  );

  function automatic bit expMig(bit a, int occ, int su, bit eg, int thr);
    if (!a || su >= SLOW) return 1'b0;
    if (eg) return 1'b1;
    return (occ + 1) * DEN > thr * FAST;
  endfunction

  function automatic string migTag(bit a, int occ, int su, bit eg, int thr);
    if (!a) return "R9";
    if (su >= SLOW) return "R6";
    if (eg) return "R5";
    if ((occ + 1) * DEN <= thr * FAST) return "R4";
    return "R3";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkCounts();
    check("R2 fastCount", int'(fastCount), mFast);
    check("R6 slowCount", int'(slowCount), mSlow);
    check("R7 startCount", int'(startCount), mStarts);
    check("R8 cancelCount", int'(cancelCount), mCancels);
  endtask

  // Called at a falling edge: drive, check migrateEn, clock, check counts.
  task automatic step(bit a, bit fd, bit md, bit mc, bit sd);
    bit em;
    arrive = a; fastDepart = fd; migDone = md; migCancel = mc; slowDepart = sd;
    #1;
    em = expMig(a, mFast, mSlow, eagerMode, int'(thrNum));
    check(migTag(a, mFast, mSlow, eagerMode, int'(thrNum)), int'(migrateEn), int'(em));
    @(posedge clk);
    mFast = mFast + int'(a) - int'(fd) - int'(md) - int'(mc);
    mSlow = mSlow + int'(em) - int'(sd) - int'(mc);
    mFlight = mFlight + int'(em) - int'(md) - int'(mc);
    mStarts += int'(em);
    mCancels += int'(mc);
    @(negedge clk);
    checkCounts();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 fastCount", int'(fastCount), 0);
    check("R1 slowCount", int'(slowCount), 0);
    check("R1 startCount", int'(startCount), 0);
    check("R1 cancelCount", int'(cancelCount), 0);
    // R3/R4: lazy fill at 50 percent, migration from the fourth flit on
    eagerMode = 0; thrNum = 4'd4;
    for (int i = 0; i < FAST; i++) step(1, 0, 0, 0, 0);
    // R9 idle cycle, then drain: finish migrations, depart the rest
    step(0, 0, 0, 0, 0);
    while (mFlight > 0) step(0, 0, 1, 0, 0);
    while (mFast > 0) step(0, 1, 0, 0, 0);
    while (mSlow > 0) step(0, 0, 0, 0, 1);
    // R5/R6: eager mode fills the slow storage, then is refused
    eagerMode = 1;
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < SLOW + 2; i++) step(1, 0, mFlight > 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0);
    // R8 cancel of an in-flight migration
    step(0, 0, 0, 1, 0);
    // R4 threshold at 100 percent: never migrates in lazy mode
    eagerMode = 0; thrNum = 4'd8;
    while (mFast > mFlight) step(0, 1, 0, 0, 0);
    while (mFlight > 0) step(0, 0, 1, 0, 0);
    while (mSlow > 0) step(0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
    // Random mix
    for (int c = 0; c < 4000; c++) begin
      bit a, fd, md, mc, sd;
      if (c % 150 == 0) begin
        eagerMode = ($urandom_range(3) == 0);
        thrNum = 4'($urandom_range(8));
      end
      a  = (mFast < FAST) && ($urandom_range(99) < 55);
      md = (mFlight > 0) && ($urandom_range(3) == 0);
      mc = (mFlight > int'(md)) && ($urandom_range(9) == 0);
      fd = (mFast > mFlight) && ($urandom_range(99) < 45);
      sd = (mSlow > mFlight) && ($urandom_range(99) < 40);
      step(a, fd, md, mc, sd);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule